// File: doc/BRIEF.md
# Permission-Tagged Micro Translation Cache

This block is a very small, fully associative cache of recent address translations that sits in front of a full TLB. It keeps two separate entry arrays: one for instruction fetches and one for data accesses. Each entry holds a 4 KB virtual page number, a physical frame number and a permission code. A lookup supplies a virtual address, the side (instruction or data) and whether the access is a write. In the same cycle the block returns hit, the physical address and the stored permission code.

On a miss the caller walks the main TLB. After a successful main-TLB translation, the caller fills an entry through the insert port and records whether the page was dirty. A write can only hit an entry that allows writing, so a read-only entry never satisfies a store. Addresses in the directly mapped kernel window never hit. A flush input empties both arrays in one cycle; it is used after any TLB update or address-space change.

Top module: `utc_top`

## Requirements
- R1: After reset every entry in both arrays is invalid, so every lookup misses (lk_hit=0).
- R2: A lookup whose lk_vaddr[31:30] equals 2'b10 always misses, even when a matching valid entry exists.
- R3: An instruction lookup (lk_side=1) searches only the instruction array, and a data lookup (lk_side=0) searches only the data array. Inserts use the same encoding on ins_side.
- R4: The requested level is 1 for a read (lk_write=0) and 2 for a write (lk_write=1). An entry hits only if its page number equals lk_vaddr[31:12] and its stored code is greater than or equal to the requested level. A write therefore misses on a read-only entry.
- R5: On a hit, lk_paddr equals {stored frame, lk_vaddr[11:0]} and lk_perm returns the stored code (1 or 2).
- R6: An insert with ins_dirty=1 stores code 2 (read/write). An insert with ins_dirty=0 stores code 1 (read-only).
- R7: Each array holds 4 entries and is refilled round-robin with its own pointer. The fifth insert into one side after a flush replaces the first page inserted on that side, and leaves the other side's entries unchanged.
- R8: While flush is asserted at a clock edge, all entries in both arrays become invalid, and both replacement pointers return to entry 0. Flush takes priority over an insert in the same cycle.
- R9: When more than one entry matches, the lowest-index entry supplies lk_paddr and lk_perm.
- R10: When lk_valid=0, the outputs lk_hit, lk_perm and lk_paddr are all 0.
- R11: An insert takes effect at the clock edge where ins_valid is sampled. A lookup in the same cycle still sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries in both arrays |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | 1 = instruction, 0 = data |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address (0 on miss) |
| lk_perm | output | 2 | Stored permission code on hit, 0 on miss |
| ins_valid | input | 1 | Insert request |
| ins_side | input | 1 | 1 = instruction array, 0 = data array |
| ins_vaddr | input | 32 | Virtual address of the page being inserted |
| ins_pfn | input | 20 | Physical frame number of the page |
| ins_dirty | input | 1 | Page dirty bit from the main TLB |

## Verification
A corrupted valid bit, page number or permission code shows up as a wrong lk_hit in the same combinational cycle as the next lookup of that page. A wrong frame shows up on lk_paddr in that same cycle. A faulty replacement pointer stays hidden until an array wraps, so the bench fills a side past capacity and then probes every inserted page. Priority errors only appear when duplicate pages are present, so the bench inserts the same page twice with different frames and different permissions.

// File: rtl/utc_pkg.sv
package utc_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;

    localparam logic SIDE_DATA  = 1'b0;
    localparam logic SIDE_INSTR = 1'b1;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2
    } perm_t;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } entry_t;

    function automatic perm_t level_of(input logic is_write);
        return is_write ? PERM_RW : PERM_RO;
    endfunction

    function automatic logic in_direct_window(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: 2] == 2'b10;
    endfunction
endpackage

// File: rtl/utc_array.sv
module utc_array
    import utc_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        ins_en,
    input  logic [VPN_W-1:0]            ins_vpn,
    input  logic [PFN_W-1:0]            ins_pfn,
    input  perm_t                       ins_perm,
    input  logic [VPN_W-1:0]            lk_vpn,
    input  perm_t                       lk_level,
    output logic [N_ENT-1:0]            match,
    output logic [N_ENT-1:0][PFN_W-1:0] pfn_out,
    output logic [N_ENT-1:0][1:0]       perm_out
);
    entry_t           ent [N_ENT];
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_next;
    logic [N_ENT-1:0] valid_vec;

    assign ptr_next = (ptr == PTR_W'(N_ENT - 1)) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent[i].valid <= 1'b0;
                ent[i].vpn   <= '0;
                ent[i].pfn   <= '0;
                ent[i].perm  <= PERM_NONE;
            end
            ptr <= '0;
        end else if (ins_en) begin
            ent[ptr] <= '{valid: 1'b1, vpn: ins_vpn, pfn: ins_pfn, perm: ins_perm};
            ptr      <= ptr_next;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign valid_vec[g] = ent[g].valid;
        assign match[g]     = ent[g].valid && (ent[g].vpn == lk_vpn)
                              && (ent[g].perm >= lk_level);
        assign pfn_out[g]   = ent[g].pfn;
        assign perm_out[g]  = ent[g].perm;
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)) else $error("flush left a valid entry"); // R8
    AST_INSERT_VALID: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush) |=> (valid_vec != '0)) else $error("insert produced no entry"); // R11
    AST_STORED_PERM_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush) |-> (ins_perm == PERM_RO || ins_perm == PERM_RW)) else $error("bad perm code stored"); // R6
endmodule

// File: rtl/utc_pick.sv
module utc_pick
    import utc_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_ENT-1:0]            req,
    input  logic [N_ENT-1:0][PFN_W-1:0] pfn_in,
    input  logic [N_ENT-1:0][1:0]       perm_in,
    output logic                        any,
    output logic [PFN_W-1:0]            pfn,
    output logic [1:0]                  perm
);
    logic [N_ENT-1:0] grant;

    always_comb begin
        grant = '0;
        pfn   = '0;
        perm  = 2'd0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                pfn   = pfn_in[i];
                perm  = perm_in[i];
            end
        end
    end

    assign any = |req;

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multiple winners"); // R9
    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0) else $error("winner without match"); // R9
endmodule

// File: rtl/utc_top.sv
module utc_top
    import utc_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_side,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [1:0]       lk_perm,
    input  logic             ins_valid,
    input  logic             ins_side,
    input  logic [VA_W-1:0]  ins_vaddr,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic             ins_dirty
);
    localparam int N_SIDE = 2;

    logic [N_SIDE-1:0][N_ENT-1:0]            side_match;
    logic [N_SIDE-1:0][N_ENT-1:0][PFN_W-1:0] side_pfn;
    logic [N_SIDE-1:0][N_ENT-1:0][1:0]       side_perm;

    perm_t            req_level;
    perm_t            ins_perm;
    logic [VPN_W-1:0] lk_vpn;
    logic             bypass;

    assign req_level = level_of(lk_write);
    assign ins_perm  = ins_dirty ? PERM_RW : PERM_RO;
    assign lk_vpn    = lk_vaddr[VA_W-1:OFF_W];
    assign bypass    = in_direct_window(lk_vaddr);

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        utc_array #(.N_ENT(N_ENT)) u_array (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .ins_en   (ins_valid && (ins_side == 1'(s))),
            .ins_vpn  (ins_vaddr[VA_W-1:OFF_W]),
            .ins_pfn  (ins_pfn),
            .ins_perm (ins_perm),
            .lk_vpn   (lk_vpn),
            .lk_level (req_level),
            .match    (side_match[s]),
            .pfn_out  (side_pfn[s]),
            .perm_out (side_perm[s])
        );
    end

    logic             pick_any;
    logic [PFN_W-1:0] pick_pfn;
    logic [1:0]       pick_perm;

    utc_pick #(.N_ENT(N_ENT)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (side_match[lk_side]),
        .pfn_in  (side_pfn[lk_side]),
        .perm_in (side_perm[lk_side]),
        .any     (pick_any),
        .pfn     (pick_pfn),
        .perm    (pick_perm)
    );

    assign lk_hit   = lk_valid && !bypass && pick_any;
    assign lk_paddr = lk_hit ? {pick_pfn, lk_vaddr[OFF_W-1:0]} : '0;
    assign lk_perm  = lk_hit ? pick_perm : 2'd0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && lk_perm == 2'd0 && lk_paddr == '0)) else $error("idle output"); // R10
    AST_WINDOW_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_vaddr[VA_W-1 -: 2] == 2'b10) |-> !lk_hit) else $error("direct window hit"); // R2
    AST_WRITE_NEEDS_RW: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_write) |-> (lk_perm == 2'd2)) else $error("write hit read-only"); // R4
    AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]
                    && (lk_perm == 2'd1 || lk_perm == 2'd2))) else $error("bad hit result"); // R5
    AST_RESET_EMPTY: assert property (@(posedge clk)
        $past(rst) |-> !lk_hit) else $error("hit right after reset"); // R1
endmodule

// File: tb/utc_top_tb.sv
module utc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0, lk_side = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_perm;
    logic        ins_valid = 1'b0, ins_side = 1'b0, ins_dirty = 1'b0;
    logic [31:0] ins_vaddr = '0;
    logic [19:0] ins_pfn = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    utc_top u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_side(lk_side), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .ins_valid(ins_valid), .ins_side(ins_side), .ins_vaddr(ins_vaddr),
        .ins_pfn(ins_pfn), .ins_dirty(ins_dirty)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Insert one page; written at the next rising edge.
    task automatic put(input logic side, input logic [31:0] va, input logic [19:0] pfn, input logic dirty);
        @(negedge clk);
        ins_valid = 1'b1; ins_side = side; ins_vaddr = va; ins_pfn = pfn; ins_dirty = dirty;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Combinational lookup, sampled 1 ns after the falling edge.
    task automatic probe(input string req, input logic side, input logic wr, input logic [31:0] va,
                         input logic hit, input logic [31:0] pa, input logic [1:0] perm);
        @(negedge clk);
        lk_valid = 1'b1; lk_side = side; lk_write = wr; lk_vaddr = va;
        #1;
        check(req, {lk_hit, lk_perm, lk_paddr[30:0]}, {hit, perm, pa[30:0]});
        check(req, {33'd0, lk_paddr[31]}, {33'd0, pa[31]});
        lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        probe("R1", 1'b0, 1'b0, 32'h0000_1000, 1'b0, 32'h0, 2'd0);
        probe("R1", 1'b1, 1'b0, 32'h0000_0000, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic t_basic();
        put(1'b0, 32'h1234_5000, 20'hABCDE, 1'b1);
        probe("R5", 1'b0, 1'b0, 32'h1234_5678, 1'b1, 32'hABCD_E678, 2'd2);
        probe("R6", 1'b0, 1'b1, 32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, 2'd2);
        put(1'b0, 32'h0040_0000, 20'h00077, 1'b0);
        probe("R6", 1'b0, 1'b0, 32'h0040_0123, 1'b1, 32'h0007_7123, 2'd1);
        probe("R4", 1'b0, 1'b1, 32'h0040_0123, 1'b0, 32'h0, 2'd0);
        probe("R4", 1'b0, 1'b0, 32'h1234_6000, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic t_side();
        probe("R3", 1'b1, 1'b0, 32'h1234_5678, 1'b0, 32'h0, 2'd0);
        put(1'b1, 32'h0000_3000, 20'h11111, 1'b0);
        probe("R3", 1'b1, 1'b0, 32'h0000_3004, 1'b1, 32'h1111_1004, 2'd1);
        probe("R3", 1'b0, 1'b0, 32'h0000_3004, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic t_bypass();
        put(1'b0, 32'h8000_2000, 20'h22222, 1'b1);
        probe("R2", 1'b0, 1'b0, 32'h8000_2010, 1'b0, 32'h0, 2'd0);
        put(1'b0, 32'hC000_2000, 20'h33333, 1'b1);
        probe("R2", 1'b0, 1'b0, 32'hC000_2010, 1'b1, 32'h3333_3010, 2'd2);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lk_valid = 1'b0; lk_side = 1'b0; lk_write = 1'b0; lk_vaddr = 32'h1234_5678;
        #1;
        check("R10", {lk_hit, lk_perm, lk_paddr}, 35'd0);
    endtask

    task automatic t_flush();
        do_flush();
        probe("R8", 1'b0, 1'b0, 32'h1234_5678, 1'b0, 32'h0, 2'd0);
        probe("R8", 1'b1, 1'b0, 32'h0000_3004, 1'b0, 32'h0, 2'd0);
        // flush and insert in the same cycle: flush wins
        @(negedge clk);
        flush = 1'b1; ins_valid = 1'b1; ins_side = 1'b0; ins_vaddr = 32'h0005_0000;
        ins_pfn = 20'h55555; ins_dirty = 1'b1;
        @(negedge clk);
        flush = 1'b0; ins_valid = 1'b0;
        probe("R8", 1'b0, 1'b0, 32'h0005_0000, 1'b0, 32'h0, 2'd0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        ins_valid = 1'b1; ins_side = 1'b1; ins_vaddr = 32'h0006_0000; ins_pfn = 20'h66666; ins_dirty = 1'b0;
        lk_valid = 1'b1; lk_side = 1'b1; lk_write = 1'b0; lk_vaddr = 32'h0006_0040;
        #1;
        check("R11", {33'd0, lk_hit}, 34'd0);
        @(negedge clk);
        ins_valid = 1'b0;
        #1;
        check("R11", {lk_hit, lk_perm, lk_paddr[30:0]}, {1'b1, 2'd1, 31'h6666_6040});
        lk_valid = 1'b0;
    endtask

    task automatic t_round_robin();
        do_flush();
        put(1'b1, 32'h0100_0000, 20'h0A000, 1'b0);
        for (int i = 0; i < 5; i++)
            put(1'b0, 32'h0200_0000 + (i << 12), 20'h0B000 + 20'(i), 1'b1);
        probe("R7", 1'b0, 1'b0, 32'h0200_0000, 1'b0, 32'h0, 2'd0);
        for (int i = 1; i < 5; i++)
            probe("R7", 1'b0, 1'b0, 32'h0200_0000 + (i << 12), 1'b1,
                  {20'h0B000 + 20'(i), 12'h000}, 2'd2);
        probe("R7", 1'b1, 1'b0, 32'h0100_0abc, 1'b1, 32'h0A00_0abc, 2'd1);
    endtask

    task automatic t_priority();
        do_flush();
        put(1'b0, 32'h0300_0000, 20'h0C001, 1'b0);
        put(1'b0, 32'h0300_0000, 20'h0C002, 1'b1);
        probe("R9", 1'b0, 1'b0, 32'h0300_0010, 1'b1, 32'h0C00_1010, 2'd1);
        probe("R9", 1'b0, 1'b1, 32'h0300_0010, 1'b1, 32'h0C00_2010, 2'd2);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_basic();
                t_side();
                t_bypass();
                t_idle();
                t_flush();
                t_same_cycle();
                t_round_robin();
                t_priority();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule